// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter and the 8-bit stack pointer of a small 8-bit controller core and works out, in one combinational pass, the address of the next instruction. The core decodes the instruction and evaluates any branch condition. It then presents the current instruction length, a control-flow code, the operand fields of the instruction (signed 8-bit displacement, 11-bit in-page field, 16-bit absolute address), the accumulator, the data pointer and the condition bit. The unit returns the next program counter and the return address that a call or an interrupt must save.

A reset request forces execution back to address zero. An interrupt request replaces the normal flow with a fixed vector: the first vector is at 0003h and the rest follow at 8-byte steps. The return address is then the address of the instruction that was pre-empted. A return from a subroutine or an interrupt uses the absolute flow code, with the core placing the two popped bytes on the absolute-address input. The stack pointer follows a grow-upward discipline. A push increments the pointer and writes at the new location. A pop reads at the current location and then decrements the pointer. All address arithmetic wraps: modulo 65536 for the program counter and modulo 256 for the stack pointer.

Top module: `pc_next_unit`

## Requirements
- R1: While rst_n is low, pc is 0000h and sp is 07h; both hold those values after rst_n rises until a step, reset request or stack operation.
- R2: When soft_rst is 1, next_pc is 0000h regardless of every other input, and pc takes that value at the next rising clock edge even if step is 0.
- R3: When soft_rst is 0 and irq_req is 1, next_pc is 0003h + 8*irq_idx and ret_addr equals the current pc, whatever the flow code.
- R4: With no reset or interrupt request, flow code 0 (sequential) and the unused codes 6 and 7 give next_pc = pc + ins_len, for ins_len of 1, 2 or 3.
- R5: Flow code 1 (unconditional relative) gives next_pc = pc + ins_len + sign-extended rel_off modulo 65536, so rel_off 80h reaches back 128 bytes; cond has no effect.
- R6: Flow code 2 (conditional relative) gives the R5 target when cond is 1 and pc + ins_len when cond is 0, with the displacement measured from pc advanced by ins_len (2 or 3).
- R7: Flow code 3 (in-page) gives next_pc whose bits 15..11 are those of pc + ins_len and whose bits 10..0 are page_addr.
- R8: Flow code 4 (absolute, also used for returns) gives next_pc = abs_addr.
- R9: Flow code 5 (indirect) gives next_pc = dptr + acc modulo 65536, with acc taken as unsigned.
- R10: With no interrupt request, ret_addr = pc + ins_len modulo 65536.
- R11: When step and soft_rst are both 0, pc keeps its value across a clock edge.
- R12: sp_op 1 (push) drives stk_addr to sp + 1 during that cycle and leaves sp = old sp + 1 (modulo 256) after the edge.
- R13: sp_op 2 (pop) drives stk_addr to sp during that cycle and leaves sp = old sp - 1 (modulo 256) after the edge; sp_op 0 and 3 leave sp unchanged with stk_addr = sp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Load pc with next_pc at this edge |
| soft_rst | input | 1 | Reset request, forces next_pc to zero and loads it |
| irq_req | input | 1 | Interrupt vector request |
| irq_idx | input | 3 | Interrupt source number selecting the vector |
| flow | input | 3 | Control-flow code (0 seq, 1 rel, 2 cond rel, 3 page, 4 abs, 5 indirect) |
| ins_len | input | 2 | Length of the current instruction in bytes (1 to 3) |
| cond | input | 1 | Branch condition for flow code 2 |
| rel_off | input | 8 | Signed relative displacement |
| page_addr | input | 11 | In-page target field |
| abs_addr | input | 16 | Absolute target or popped return address |
| acc | input | 8 | Accumulator value, unsigned index |
| dptr | input | 16 | Data pointer, base of indirect jumps |
| sp_op | input | 2 | Stack operation (0 none, 1 push, 2 pop, 3 none) |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Computed address of the next instruction |
| ret_addr | output | 16 | Return address to save for a call or interrupt |
| sp | output | 8 | Current stack pointer |
| stk_addr | output | 8 | Internal RAM address of this cycle's stack access |

## Verification
The relative and indirect targets are swept over every displacement and every accumulator value, starting from program counters near 0000h, FFFEh and a 2 KB page boundary. These sweeps separate sign extension from zero extension and show whether the sum wraps or carries into a 17th bit. The in-page mode is tried with instruction lengths whose advance crosses a page edge, which shows whether the upper bits come from the advanced or the current counter. Interrupt vectors are walked over all sources together with conflicting flow codes and a reset request, to confirm the priority order. The stack pointer is pushed and popped across its 00h/FFh wrap to separate pre-increment addressing from post-decrement addressing.

// File: rtl/pnu_pkg.sv
package pnu_pkg;
   localparam int FLOW_W = 3;
   localparam int SPOP_W = 2;

   typedef enum logic [FLOW_W-1:0] {
      FL_SEQ  = 3'd0,
      FL_REL  = 3'd1,
      FL_BRC  = 3'd2,
      FL_PAGE = 3'd3,
      FL_ABS  = 3'd4,
      FL_IND  = 3'd5
   } flow_e;

   typedef enum logic [SPOP_W-1:0] {
      SP_HOLD = 2'd0,
      SP_PUSH = 2'd1,
      SP_POP  = 2'd2
   } spop_e;
endpackage

// File: rtl/pnu_targets.sv
module pnu_targets #(
   parameter int PC_W   = 16,
   parameter int OFS_W  = 8,
   parameter int PAGE_W = 11,
   parameter int ACC_W  = 8,
   parameter int LEN_W  = 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [LEN_W-1:0]  ins_len,
   input  logic [OFS_W-1:0]  rel_off,
   input  logic [PAGE_W-1:0] page_addr,
   input  logic [PC_W-1:0]   dptr,
   input  logic [ACC_W-1:0]  acc,
   output logic [PC_W-1:0]   adv,
   output logic [PC_W-1:0]   t_rel,
   output logic [PC_W-1:0]   t_page,
   output logic [PC_W-1:0]   t_ind
);
   logic [PC_W-1:0] rel_x;

   // displacement is widened by sign, or truncated when already wide enough
   generate
      if (OFS_W >= PC_W) begin : g_ofs_trunc
         assign rel_x = rel_off[PC_W-1:0];
      end else begin : g_ofs_sext
         assign rel_x = {{(PC_W-OFS_W){rel_off[OFS_W-1]}}, rel_off};
      end
   endgenerate

   assign adv    = pc + PC_W'(ins_len);
   assign t_rel  = adv + rel_x;
   assign t_page = {adv[PC_W-1:PAGE_W], page_addr};
   assign t_ind  = dptr + PC_W'(acc);
endmodule

// File: rtl/pnu_select.sv
module pnu_select
   import pnu_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int VEC_IDX_W = 3,
   parameter int VEC_BASE  = 3,
   parameter int VEC_SHIFT = 3
) (
   input  logic                 soft_rst,
   input  logic                 irq_req,
   input  logic [VEC_IDX_W-1:0] irq_idx,
   input  logic [FLOW_W-1:0]    flow,
   input  logic                 cond,
   input  logic [PC_W-1:0]      pc,
   input  logic [PC_W-1:0]      adv,
   input  logic [PC_W-1:0]      t_rel,
   input  logic [PC_W-1:0]      t_page,
   input  logic [PC_W-1:0]      t_abs,
   input  logic [PC_W-1:0]      t_ind,
   output logic [PC_W-1:0]      next_pc,
   output logic [PC_W-1:0]      ret_addr
);
   logic [PC_W-1:0] vec_pc;
   logic [PC_W-1:0] flow_pc;

   assign vec_pc = PC_W'(VEC_BASE) + (PC_W'(irq_idx) << VEC_SHIFT);

   always_comb begin
      case (flow)
         FL_REL:  flow_pc = t_rel;
         FL_BRC:  flow_pc = cond ? t_rel : adv;
         FL_PAGE: flow_pc = t_page;
         FL_ABS:  flow_pc = t_abs;
         FL_IND:  flow_pc = t_ind;
         default: flow_pc = adv;
      endcase
   end

   // reset request outranks interrupt, interrupt outranks the instruction
   always_comb begin
      if (soft_rst)     next_pc = '0;
      else if (irq_req) next_pc = vec_pc;
      else              next_pc = flow_pc;
   end

   assign ret_addr = irq_req ? pc : adv;
endmodule

// File: rtl/pnu_stack.sv
module pnu_stack
   import pnu_pkg::*;
#(
   parameter int SP_W   = 8,
   parameter int SP_RST = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SPOP_W-1:0] sp_op,
   output logic [SP_W-1:0]   sp,
   output logic [SP_W-1:0]   stk_addr
);
   logic [SP_W-1:0] sp_inc;
   logic [SP_W-1:0] sp_dec;

   assign sp_inc = sp + SP_W'(1);
   assign sp_dec = sp - SP_W'(1);

   // push addresses the slot above; pop addresses the current slot
   assign stk_addr = (sp_op == SP_PUSH) ? sp_inc : sp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= SP_W'(SP_RST);
      end else begin
         case (sp_op)
            SP_PUSH: sp <= sp_inc;
            SP_POP:  sp <= sp_dec;
            default: sp <= sp;
         endcase
      end
   end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pnu_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int OFS_W     = 8,
   parameter int PAGE_W    = 11,
   parameter int ACC_W     = 8,
   parameter int LEN_W     = 2,
   parameter int SP_W      = 8,
   parameter int SP_RST    = 7,
   parameter int VEC_IDX_W = 3,
   parameter int VEC_BASE  = 3,
   parameter int VEC_SHIFT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 soft_rst,
   input  logic                 irq_req,
   input  logic [VEC_IDX_W-1:0] irq_idx,
   input  logic [2:0]           flow,
   input  logic [LEN_W-1:0]     ins_len,
   input  logic                 cond,
   input  logic [OFS_W-1:0]     rel_off,
   input  logic [PAGE_W-1:0]    page_addr,
   input  logic [PC_W-1:0]      abs_addr,
   input  logic [ACC_W-1:0]     acc,
   input  logic [PC_W-1:0]      dptr,
   input  logic [1:0]           sp_op,
   output logic [PC_W-1:0]      pc,
   output logic [PC_W-1:0]      next_pc,
   output logic [PC_W-1:0]      ret_addr,
   output logic [SP_W-1:0]      sp,
   output logic [SP_W-1:0]      stk_addr
);
   generate
      if (PAGE_W >= PC_W) begin : g_bad_page
         $error("PAGE_W must be below PC_W");
      end
      if (ACC_W > PC_W) begin : g_bad_acc
         $error("ACC_W must not exceed PC_W");
      end
      if (VEC_IDX_W + VEC_SHIFT >= PC_W) begin : g_bad_vec
         $error("vector table does not fit the address space");
      end
      if (SP_W < 2) begin : g_bad_sp
         $error("SP_W too small");
      end
   endgenerate

   logic [PC_W-1:0] adv, t_rel, t_page, t_ind;

   pnu_targets #(
      .PC_W(PC_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W),
      .ACC_W(ACC_W), .LEN_W(LEN_W)
   ) u_tgt (
      .pc(pc), .ins_len(ins_len), .rel_off(rel_off),
      .page_addr(page_addr), .dptr(dptr), .acc(acc),
      .adv(adv), .t_rel(t_rel), .t_page(t_page), .t_ind(t_ind)
   );

   pnu_select #(
      .PC_W(PC_W), .VEC_IDX_W(VEC_IDX_W),
      .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
   ) u_sel (
      .soft_rst(soft_rst), .irq_req(irq_req), .irq_idx(irq_idx),
      .flow(flow), .cond(cond), .pc(pc), .adv(adv), .t_rel(t_rel),
      .t_page(t_page), .t_abs(abs_addr), .t_ind(t_ind),
      .next_pc(next_pc), .ret_addr(ret_addr)
   );

   pnu_stack #(
      .SP_W(SP_W), .SP_RST(SP_RST)
   ) u_stk (
      .clk(clk), .rst_n(rst_n), .sp_op(sp_op),
      .sp(sp), .stk_addr(stk_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pc <= '0;
      else if (step || soft_rst) pc <= next_pc;
   end
endmodule

// File: rtl/pnu_checker.sv
module pnu_checker #(
   parameter int PC_W      = 16,
   parameter int LEN_W     = 2,
   parameter int SP_W      = 8,
   parameter int VEC_BASE  = 3,
   parameter int VEC_SHIFT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic             soft_rst,
   input logic             irq_req,
   input logic [2:0]       flow,
   input logic [LEN_W-1:0] ins_len,
   input logic [1:0]       sp_op,
   input logic [PC_W-1:0]  pc,
   input logic [SP_W-1:0]  sp
);
   localparam logic [PC_W-1:0] VMASK = PC_W'((1 << VEC_SHIFT) - 1);
   localparam logic [PC_W-1:0] VLOW  = PC_W'(VEC_BASE) & VMASK;

   a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> pc == '0);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !soft_rst) |=> pc == $past(pc));

   a_r3_vector_align: assert property (@(posedge clk) disable iff (!rst_n)
      (step && irq_req && !soft_rst) |=> (pc & VMASK) == VLOW);

   a_r4_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !soft_rst && !irq_req && flow == 3'd0)
      |=> pc == PC_W'($past(pc) + PC_W'($past(ins_len))));

   a_r12_push: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_op == 2'd1) |=> sp == SP_W'($past(sp) + SP_W'(1)));

   a_r13_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_op == 2'd2) |=> sp == SP_W'($past(sp) - SP_W'(1)));
endmodule

bind pc_next_unit pnu_checker #(
   .PC_W(PC_W), .LEN_W(LEN_W), .SP_W(SP_W),
   .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step), .soft_rst(soft_rst),
   .irq_req(irq_req), .flow(flow), .ins_len(ins_len), .sp_op(sp_op),
   .pc(pc), .sp(sp)
);

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        step, soft_rst, irq_req, cond;
   logic [2:0]  irq_idx, flow;
   logic [1:0]  ins_len, sp_op;
   logic [7:0]  rel_off, acc;
   logic [10:0] page_addr;
   logic [15:0] abs_addr, dptr;
   logic [15:0] pc, next_pc, ret_addr;
   logic [7:0]  sp, stk_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pc_next_unit u0 (
      .clk(clk), .rst_n(rst_n), .step(step), .soft_rst(soft_rst),
      .irq_req(irq_req), .irq_idx(irq_idx), .flow(flow), .ins_len(ins_len),
      .cond(cond), .rel_off(rel_off), .page_addr(page_addr),
      .abs_addr(abs_addr), .acc(acc), .dptr(dptr), .sp_op(sp_op),
      .pc(pc), .next_pc(next_pc), .ret_addr(ret_addr),
      .sp(sp), .stk_addr(stk_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // inputs change just after a falling edge; combinational outputs read 1 ns later
   task automatic settle();
      #1;
   endtask

   task automatic edge_then_fall();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_pc(input logic [15:0] v);
      soft_rst = 0; irq_req = 0; flow = 3'd4; abs_addr = v; step = 1;
      edge_then_fall();
      step = 0;
      settle();
      check("R8 load", {16'h0, pc}, {16'h0, v});
   endtask

   function automatic logic [15:0] sx(input logic [7:0] o);
      return {{8{o[7]}}, o};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] pcs [5];
      logic [15:0] p, e;
      pcs[0] = 16'h0000; pcs[1] = 16'h07FE; pcs[2] = 16'h1234;
      pcs[3] = 16'hF7FF; pcs[4] = 16'hFFFE;

      rst_n = 0; step = 0; soft_rst = 0; irq_req = 0; irq_idx = 0; cond = 0;
      flow = 0; ins_len = 1; sp_op = 0; rel_off = 0; acc = 0;
      page_addr = 0; abs_addr = 0; dptr = 0;
      repeat (3) @(negedge clk);
      settle();
      check("R1 pc in reset", {16'h0, pc}, 32'h0);
      check("R1 sp in reset", {24'h0, sp}, 32'h07);
      rst_n = 1;
      edge_then_fall();
      settle();
      check("R1 pc after reset", {16'h0, pc}, 32'h0);
      check("R1 sp after reset", {24'h0, sp}, 32'h07);

      for (int k = 0; k < 5; k++) begin
         load_pc(pcs[k]);
         p = pcs[k];
         // R4 sequential and unused codes, R10 return address
         foreach (pcs[j]) begin end
         for (int f = 0; f < 8; f++) begin
            if (f == 0 || f == 6 || f == 7) begin
               for (int l = 1; l <= 3; l++) begin
                  flow = 3'(f); ins_len = 2'(l); settle();
                  e = p + 16'(l);
                  check("R4 sequential", {16'h0, next_pc}, {16'h0, e});
                  check("R10 ret addr", {16'h0, ret_addr}, {16'h0, e});
               end
            end
         end
         // R5 every displacement, cond low has no effect
         flow = 3'd1; ins_len = 2; cond = 0;
         for (int o = 0; o < 256; o++) begin
            rel_off = 8'(o); settle();
            e = p + 16'd2 + sx(8'(o));
            check("R5 relative", {16'h0, next_pc}, {16'h0, e});
         end
         // R6 conditional, 3-byte form
         flow = 3'd2; ins_len = 3;
         for (int o = 0; o < 4; o++) begin
            rel_off = (o == 0) ? 8'h80 : (o == 1) ? 8'hFF : (o == 2) ? 8'h00 : 8'h7F;
            cond = 1; settle();
            e = p + 16'd3 + sx(rel_off);
            check("R6 taken", {16'h0, next_pc}, {16'h0, e});
            cond = 0; settle();
            check("R6 not taken", {16'h0, next_pc}, {16'h0, p + 16'd3});
         end
         // R7 in-page, upper bits from the advanced counter
         flow = 3'd3;
         for (int l = 2; l <= 3; l++) begin
            for (int g = 0; g < 3; g++) begin
               ins_len = 2'(l);
               page_addr = (g == 0) ? 11'h000 : (g == 1) ? 11'h7FF : 11'h555;
               settle();
               e = ((p + 16'(l)) & 16'hF800) | {5'h0, page_addr};
               check("R7 in-page", {16'h0, next_pc}, {16'h0, e});
            end
         end
         // R8 absolute
         flow = 3'd4; abs_addr = ~p; settle();
         check("R8 absolute", {16'h0, next_pc}, {16'h0, ~p});
         // R9 indirect, every accumulator value
         flow = 3'd5;
         for (int d = 0; d < 2; d++) begin
            dptr = (d == 0) ? 16'h0000 : 16'hFF80;
            for (int a = 0; a < 256; a++) begin
               acc = 8'(a); settle();
               e = dptr + 16'(a);
               check("R9 indirect", {16'h0, next_pc}, {16'h0, e});
            end
         end
      end

      // R3 vectors over all sources, against a conflicting flow code
      load_pc(16'h4321);
      flow = 3'd4; abs_addr = 16'hBEEF; irq_req = 1;
      for (int i = 0; i < 8; i++) begin
         irq_idx = 3'(i); settle();
         check("R3 vector", {16'h0, next_pc}, 32'(3 + 8 * i));
         check("R3 ret addr", {16'h0, ret_addr}, 32'h4321);
      end
      irq_idx = 2; step = 1;
      edge_then_fall();
      step = 0; settle();
      check("R3 pc at vector", {16'h0, pc}, 32'h0013);

      // R2 reset request beats interrupt, loads without step
      irq_req = 1; irq_idx = 5; soft_rst = 1; step = 0; settle();
      check("R2 next_pc zero", {16'h0, next_pc}, 32'h0);
      edge_then_fall();
      soft_rst = 0; irq_req = 0; settle();
      check("R2 pc zero", {16'h0, pc}, 32'h0);

      // R11 hold without step
      load_pc(16'h2468);
      flow = 3'd4; abs_addr = 16'hABCD; step = 0;
      edge_then_fall();
      settle();
      check("R11 pc held", {16'h0, pc}, 32'h2468);

      // R12 push addressing and wrap
      for (int n = 0; n < 249; n++) begin
         sp_op = 2'd1; settle();
         check("R12 push address", {24'h0, stk_addr}, {24'h0, 8'(sp + 8'd1)});
         edge_then_fall();
      end
      sp_op = 0; settle();
      check("R12 sp after pushes wraps", {24'h0, sp}, 32'h00);
      // R13 pop addressing and wrap
      sp_op = 2'd2; settle();
      check("R13 pop address", {24'h0, stk_addr}, 32'h00);
      edge_then_fall();
      sp_op = 0; settle();
      check("R13 sp after pop wraps", {24'h0, sp}, 32'hFF);
      check("R13 hold address", {24'h0, stk_addr}, 32'hFF);
      sp_op = 2'd3;
      edge_then_fall();
      settle();
      check("R13 code 3 holds", {24'h0, sp}, 32'hFF);
      sp_op = 2'd2;
      edge_then_fall();
      sp_op = 0; settle();
      check("R13 sp decrement", {24'h0, sp}, 32'hFE);

      finish_run();
   end
endmodule